// File: doc/BRIEF.md
# Retriggerable Digital Monostable Pulse Generator

This block is a clocked, fully synchronous one-shot. Three asynchronous control levels are brought in through a synchronizer: a falling-edge trigger input, a rising-edge trigger input and an active-low clear. Each input qualifies the others. An accepted edge loads a down-counter with a 16-bit width value. The high output stays asserted for exactly that many clock cycles. The clear input can also start a pulse on its own release, provided the two trigger levels permit it.

Any trigger accepted while a pulse is running reloads the counter with the full width. A trigger train that arrives faster than the width therefore holds the output high without a gap. Pulling the clear input low drops the output as soon as the synchronized level arrives, and no trigger is accepted while it stays low. The block drives a true output and its complement.

The inputs are plain control levels, so there is no valid/ready handshake and no back-pressure. Every pin is a level, and the block never stalls its environment.

Top module: `retrig_pulse`

## Requirements
- R1: A high-to-low change on `fall_trig_i` starts a pulse only if the synchronized `rise_trig_i` is high and `clear_n_i` is high at that moment.
- R2: A low-to-high change on `rise_trig_i` starts a pulse only if the synchronized `fall_trig_i` is low and `clear_n_i` is high.
- R3: A low-to-high change on `clear_n_i` starts a pulse when the synchronized `fall_trig_i` is low and `rise_trig_i` is high.
- R4: While `fall_trig_i` is held high, or `rise_trig_i` is held low, toggling the other inputs never raises `pulse_o`.
- R5: While synchronized `clear_n_i` is low, no trigger is accepted. A running pulse drops at the second rising clock edge after `clear_n_i` goes low.
- R6: An input change that starts a pulse raises `pulse_o` at the third rising edge after that change: two synchronizer stages, then the counter load. `pulse_o` then stays high for exactly `width_i` cycles unless it is cleared or retriggered.
- R7: A trigger accepted during a pulse restarts the full width from that trigger. A trigger train with a period shorter than the width keeps `pulse_o` continuously high until the width after the last trigger has run out.
- R8: `width_i` is sampled, as an unsigned value, on the clock edge where a trigger is accepted. Later changes do not affect the running pulse, and a width of zero produces no pulse.
- R9: `pulse_n_o` is always the inverse of `pulse_o`.
- R10: Synchronous reset `rst` forces `pulse_o` low, `pulse_n_o` high and the counter to zero. It also loads the synchronizer stages with an idle pattern (falling-edge input high, rising-edge input low, clear low), so no trigger is seen in the first cycles after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fall_trig_i | input | 1 | Asynchronous trigger level; its high-to-low change is a trigger candidate |
| rise_trig_i | input | 1 | Asynchronous trigger level; its low-to-high change is a trigger candidate |
| clear_n_i | input | 1 | Asynchronous active-low clear; its release is also a trigger candidate |
| width_i | input | 16 | Pulse width in clock cycles, sampled at each accepted trigger |
| pulse_o | output | 1 | One-shot output |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
The assertions assume that reset is applied from time zero. They also assume that the trigger levels do not glitch faster than the synchronizer can follow, so each change the checker sees on the synchronized levels is one the stimulus made on purpose. The bench changes only one control level per step, always on a falling clock edge, and holds each level for at least three cycles. It also restores the idle levels in an order that cannot itself form a trigger, so every pulse the bench observes is one it meant to cause. `width_i` is held steady from the input change until the counter has loaded, except in the scenario that checks sampling.

// File: rtl/pulse_gen_pkg.sv
package pulse_gen_pkg;
  typedef struct packed {
    logic fall_lvl;
    logic rise_lvl;
    logic clr_n;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  localparam ctl_t CTL_IDLE = '{fall_lvl: 1'b1, rise_lvl: 1'b0, clr_n: 1'b0};
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int STAGES = 2,
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= RST_VAL;
    else     stage_q[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[g] <= RST_VAL;
      else     stage_q[g] <= stage_q[g-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pg_trig_gate.sv
module pg_trig_gate
  import pulse_gen_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ctl_t lvl,
  output logic fire
);
  ctl_t prev_q;
  logic fall_edge, rise_edge, clr_edge;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= CTL_IDLE;
    else     prev_q <= lvl;
  end

  always_comb begin
    fall_edge = prev_q.fall_lvl & ~lvl.fall_lvl;
    rise_edge = ~prev_q.rise_lvl & lvl.rise_lvl;
    clr_edge  = ~prev_q.clr_n & lvl.clr_n;
    fire = (fall_edge & lvl.rise_lvl & lvl.clr_n)
         | (rise_edge & ~lvl.fall_lvl & lvl.clr_n)
         | (clr_edge & ~lvl.fall_lvl & lvl.rise_lvl);
  end
endmodule

// File: rtl/pg_timer.sv
module pg_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          clr_n,
  input  logic [CW-1:0] width,
  output logic [CW-1:0] cnt_q,
  output logic          active
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (!clr_n)        cnt_q <= '0;
    else if (fire)          cnt_q <= width;
    else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
  end

  assign active = (cnt_q != '0) && clr_n;
endmodule

// File: rtl/retrig_pulse.sv
module retrig_pulse
  import pulse_gen_pkg::*;
#(
  parameter int WIDTH_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fall_trig_i,
  input  logic               rise_trig_i,
  input  logic               clear_n_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               pulse_o,
  output logic               pulse_n_o
);
  ctl_t               raw_lvl;
  ctl_t               lvl_s;
  logic               fire;
  logic [WIDTH_W-1:0] cnt_q;
  logic               active;

  assign raw_lvl = '{fall_lvl: fall_trig_i, rise_lvl: rise_trig_i, clr_n: clear_n_i};

  pg_sync #(
    .STAGES (SYNC_STAGES),
    .W      (CTL_W),
    .RST_VAL(CTL_IDLE)
  ) sync_i (
    .clk(clk),
    .rst(rst),
    .d  (raw_lvl),
    .q  (lvl_s)
  );

  pg_trig_gate gate_i (
    .clk (clk),
    .rst (rst),
    .lvl (lvl_s),
    .fire(fire)
  );

  pg_timer #(.CW(WIDTH_W)) timer_i (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .clr_n (lvl_s.clr_n),
    .width (width_i),
    .cnt_q (cnt_q),
    .active(active)
  );

  assign pulse_o   = active;
  assign pulse_n_o = ~active;
endmodule

// File: rtl/pg_checker.sv
module pg_checker
  import pulse_gen_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input ctl_t          lvl,
  input logic          fire,
  input logic [CW-1:0] width,
  input logic [CW-1:0] cnt,
  input logic          pulse_o,
  input logic          pulse_n_o
);
  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst) pulse_n_o == !pulse_o); // R9
  AST_CLEAR_BLOCKS_FIRE: assert property (@(posedge clk) disable iff (rst) !lvl.clr_n |-> !fire); // R5
  AST_CLEAR_DROPS_PULSE: assert property (@(posedge clk) disable iff (rst) !lvl.clr_n |-> !pulse_o); // R5
  AST_FALL_HIGH_BLOCKS: assert property (@(posedge clk) disable iff (rst) (lvl.fall_lvl && $past(lvl.fall_lvl)) |-> !fire); // R4
  AST_RISE_LOW_BLOCKS: assert property (@(posedge clk) disable iff (rst) (!lvl.rise_lvl && !$past(lvl.rise_lvl)) |-> !fire); // R4
  AST_FIRE_STARTS: assert property (@(posedge clk) disable iff (rst) (fire && width != '0) |=> (pulse_o || !lvl.clr_n)); // R6
  AST_FIRE_LOADS: assert property (@(posedge clk) disable iff (rst) (fire) |=> (cnt == $past(width) || !$past(lvl.clr_n))); // R7
  AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (rst) (fire && width == '0) |=> !pulse_o); // R8
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst) (pulse_o && !fire) |=> cnt == $past(cnt) - CW'(1)); // R6
  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (rst) $rose(pulse_o) |-> $past(fire)); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (cnt == '0 && !pulse_o && pulse_n_o)); // R10
endmodule

bind retrig_pulse pg_checker #(.CW(WIDTH_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .lvl      (lvl_s),
  .fire     (fire),
  .width    (width_i),
  .cnt      (cnt_q),
  .pulse_o  (pulse_o),
  .pulse_n_o(pulse_n_o)
);

// File: tb/retrig_pulse_tb_top.sv
`timescale 1ns/1ps
module retrig_pulse_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fall_trig = 1'b1;
  logic        rise_trig = 1'b0;
  logic        clear_n = 1'b1;
  logic [15:0] width = 16'd5;
  logic        pulse_o, pulse_n_o;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  retrig_pulse dut_i (
    .clk(clk), .rst(rst),
    .fall_trig_i(fall_trig), .rise_trig_i(rise_trig), .clear_n_i(clear_n),
    .width_i(width), .pulse_o(pulse_o), .pulse_n_o(pulse_n_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Samples n falling edges; first = index of first high sample (-1 if none).
  task automatic observe(input int n, output int first, output int cnt_hi, output int bad_cmp);
    first = -1; cnt_hi = 0; bad_cmp = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (pulse_n_o == pulse_o) bad_cmp++;
      if (pulse_o) begin
        if (first < 0) first = i;
        cnt_hi++;
      end
    end
  endtask

  task automatic t_reset();
    chk(pulse_o == 1'b0, "R10 pulse_o in reset", int'(pulse_o), 0);
    chk(pulse_n_o == 1'b1, "R10 pulse_n_o in reset", int'(pulse_n_o), 1);
    @(negedge clk); rst = 1'b0;
    wait_n(5);
    chk(pulse_o == 1'b0, "R10 no pulse after reset release", int'(pulse_o), 0);
  endtask

  task automatic t_fall_trigger();
    int f, c, b;
    width = 16'd5;
    rise_trig = 1'b1;          // rising edge while fall input high: no trigger
    observe(6, f, c, b);
    chk(c == 0, "R4 rise edge with fall input high", c, 0);
    fall_trig = 1'b0;
    observe(12, f, c, b);
    chk(f == 3, "R6 start latency via fall edge", f, 3);
    chk(c == 5, "R1 pulse width via fall edge", c, 5);
    chk(b == 0, "R9 complement during pulse", b, 0);
    fall_trig = 1'b1; wait_n(4);
    rise_trig = 1'b0; wait_n(4);
  endtask

  task automatic t_rise_trigger();
    int f, c, b;
    width = 16'd7;
    fall_trig = 1'b0;          // falling edge while rise input low: no trigger
    observe(6, f, c, b);
    chk(c == 0, "R4 fall edge with rise input low", c, 0);
    rise_trig = 1'b1;
    observe(14, f, c, b);
    chk(f == 3, "R2 start latency via rise edge", f, 3);
    chk(c == 7, "R2 pulse width via rise edge", c, 7);
    fall_trig = 1'b1; wait_n(4);
    rise_trig = 1'b0; wait_n(4);
  endtask

  task automatic t_clear_release();
    int f, c, b;
    width = 16'd4;
    clear_n = 1'b0; wait_n(4);
    fall_trig = 1'b0; wait_n(4);
    rise_trig = 1'b1;
    observe(6, f, c, b);
    chk(c == 0, "R5 triggers ignored while clear low", c, 0);
    clear_n = 1'b1;
    observe(10, f, c, b);
    chk(f == 3, "R3 start latency via clear release", f, 3);
    chk(c == 4, "R3 pulse width via clear release", c, 4);
    fall_trig = 1'b1; wait_n(4);
    rise_trig = 1'b0; wait_n(4);
  endtask

  task automatic t_fall_high_blocks();
    int f, c, b;
    width = 16'd5;
    rise_trig = 1'b1; wait_n(4);
    rise_trig = 1'b0; wait_n(4);
    clear_n = 1'b0; wait_n(4);
    clear_n = 1'b1;
    observe(10, f, c, b);
    chk(c == 0, "R4 fall input held high blocks all", c, 0);
  endtask

  task automatic t_clear_cut();
    int f, c, b;
    width = 16'd20;
    rise_trig = 1'b1; wait_n(4);
    fall_trig = 1'b0;
    observe(5, f, c, b);
    chk(pulse_o == 1'b1, "R5 pulse running before clear", int'(pulse_o), 1);
    clear_n = 1'b0;
    @(negedge clk);
    chk(pulse_o == 1'b1, "R5 still high one edge after clear", int'(pulse_o), 1);
    @(negedge clk);
    chk(pulse_o == 1'b0, "R5 low two edges after clear", int'(pulse_o), 0);
    fall_trig = 1'b1; wait_n(4);
    clear_n = 1'b1; wait_n(4);
    rise_trig = 1'b0;
    observe(25, f, c, b);
    chk(c == 0, "R5 pulse stays ended after clear", c, 0);
  endtask

  task automatic t_retrigger();
    int first = -1, last = -1, c = 0;
    width = 16'd10;
    rise_trig = 1'b1; wait_n(4);
    fall_trig = 1'b0;          // first fall edge at index 0
    for (int i = 1; i <= 50; i++) begin
      @(negedge clk);
      if (pulse_o) begin
        if (first < 0) first = i;
        last = i; c++;
      end
      if (i < 27) fall_trig = ((i % 6) < 3) ? 1'b0 : 1'b1;
      else        fall_trig = 1'b1;
    end
    chk(first == 3, "R7 train start", first, 3);
    chk(last == 36, "R7 end = last trigger + full width", last, 36);
    chk(c == 34, "R7 output high without gap", c, 34);
    rise_trig = 1'b0; wait_n(4);
  endtask

  task automatic t_zero_width();
    int f, c, b;
    width = 16'd0;
    rise_trig = 1'b1; wait_n(4);
    fall_trig = 1'b0;
    observe(10, f, c, b);
    chk(c == 0, "R8 zero width gives no pulse", c, 0);
    fall_trig = 1'b1; wait_n(4);
    rise_trig = 1'b0; wait_n(4);
  endtask

  task automatic t_width_sampled();
    int c = 0;
    width = 16'd6;
    rise_trig = 1'b1; wait_n(4);
    fall_trig = 1'b0;
    wait_n(3);
    if (pulse_o) c++;
    width = 16'd30;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pulse_o) c++;
    end
    chk(c == 6, "R8 width sampled at trigger", c, 6);
    fall_trig = 1'b1; wait_n(4);
    rise_trig = 1'b0; wait_n(4);
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL R6 watchdog expired actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_n(4);
    t_reset();
    t_fall_trigger();
    t_rise_trigger();
    t_clear_release();
    t_fall_high_blocks();
    t_clear_cut();
    t_retrigger();
    t_zero_width();
    t_width_sampled();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule